// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes one received Ethernet frame and writes it into a page of packet memory. It first accepts a frame descriptor carrying the frame length, then a byte stream with the frame contents. It asks a page allocator for a free page and writes a fixed layout into that page: a 16-bit status word, a 16-bit stored byte count, the even-length part of the payload (zero-padded up to a minimum frame size), an optional 4-byte CRC, and a two-byte trailer made of the final odd data byte and a control byte. When the last byte has been written, the page number is pushed to the receive queue and a one-cycle receive-complete pulse is raised.

Frames that cannot be stored are dropped. This happens when the receiver is disabled, when soft reset is held, when the stored image would not fit in a page, or when the allocator has no free page. Their bytes are still taken from the stream so that the next frame stays aligned.

Both input channels use valid/ready handshakes. The descriptor channel is ready only while the block is idle. A transfer happens on a rising edge where valid and ready are both high. The byte channel is ready only while the block still needs a payload byte of the current frame, or while it drains a dropped frame. The upstream source may hold byte valid low for any number of cycles. The block takes at most one byte per cycle and never takes more bytes than the descriptor length. Enable, soft reset and CRC-strip are plain level inputs, sampled in the cycle the descriptor is accepted.

Top module: `rxfw_writer`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a frame, the descriptor ready is high, the byte ready is low, and no memory write, queue push or done pulse occurs.
- R2: A frame whose descriptor is accepted while `rx_en` is low or `soft_rst` is high issues no allocation request and makes no memory write, push or done pulse. All of its `len` bytes are still consumed.
- R3: A frame whose stored byte count exceeds `PAGE_BYTES` is dropped in the same way, with no allocation request. A stored count exactly equal to `PAGE_BYTES` is kept.
- R4: When the allocator answers with the code 0x80 (no page free), the frame is dropped, its bytes are consumed, and nothing is written.
- R5: Page bytes 0..3 hold the status word and then the stored count, each low byte first. The count is E+6, plus 4 when CRC stripping is off, where E is the even part of the padded length. The payload bytes occupy addresses 4..4+E-1 in arrival order.
- R6: A frame shorter than `MIN_FRAME` bytes is stored as `MIN_FRAME` bytes, with zero bytes after the received data. A padded frame is never marked odd.
- R7: Status bit 12 (0x1000) is set when the padded length is odd. Status bit 11 (0x0800) is set when the padded length exceeds `MAX_FRAME`. All other status bits are zero.
- R8: With `strip_crc` low, the 4 bytes after the even payload hold the standard Ethernet CRC-32 of all padded payload bytes, including a final odd byte, least significant byte first. This is the reflected polynomial 0xEDB88320, with an all-ones start value and a complemented result. With `strip_crc` high, no CRC bytes are stored.
- R9: The last two stored bytes are the final data byte followed by control byte 0x20 for an odd padded length, and 0x00, 0x00 for an even one.
- R10: A stored frame makes exactly count writes, all to the allocated page. `rx_done` and `rxq_push` are high together for a single cycle, in the cycle right after the final write, with `rxq_page` equal to the allocated page.
- R11: The descriptor ready and the byte ready are never high together, and the stored image is identical when the byte source inserts idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable, sampled at descriptor accept |
| soft_rst | input | 1 | Soft reset held, frames are dropped |
| strip_crc | input | 1 | High: do not store the CRC |
| hdr_valid | input | 1 | Frame descriptor valid |
| hdr_ready | output | 1 | Frame descriptor ready (idle) |
| hdr_len | input | LEN_W | Frame length in bytes |
| byte_valid | input | 1 | Payload byte valid |
| byte_ready | output | 1 | Payload byte ready |
| byte_data | input | 8 | Payload byte |
| alloc_req | output | 1 | Page request, pulsed at descriptor accept |
| alloc_page | input | 8 | Allocator answer in the same cycle, 0x80 = none |
| mem_we | output | 1 | Packet memory write strobe |
| mem_page | output | 8 | Page being written |
| mem_addr | output | ADDR_W | Byte address within the page |
| mem_wdata | output | 8 | Byte to write |
| rxq_push | output | 1 | Push the page number to the receive queue |
| rxq_page | output | 8 | Page number pushed |
| rx_done | output | 1 | Receive-complete pulse |

## Verification
The bench builds the block with `PAGE_BYTES`=256, `MAX_FRAME`=120, `MIN_FRAME`=64 and `LEN_W`=10. With a 256-byte page, both sides of the oversize limit can be reached with short frames: length 247 (CRC kept) and length 251 (CRC stripped) give a stored count of exactly 256, while 248 and 252 are dropped. A `MAX_FRAME` of 120 puts the over-long flag edge at lengths 120 and 121, inside the same short runs. The default minimum of 64 keeps padding, zero-length frames and odd frames just above the minimum in reach as well.

// File: rtl/rxfw_pkg.sv
package rxfw_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_HEAD,
    RX_BODY,
    RX_FCS,
    RX_TAIL,
    RX_DONE,
    RX_DRAIN
  } rx_phase_e;

  localparam logic [7:0]  PAGE_NONE = 8'h80;
  localparam logic [15:0] STAT_ODD  = 16'h1000;
  localparam logic [15:0] STAT_LONG = 16'h0800;
  localparam logic [7:0]  CTRL_ODD  = 8'h20;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  // one byte through the reflected CRC-32 register, LSB first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxfw_plan.sv
module rxfw_plan
  import rxfw_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int PAGE_BYTES = 2048,
  localparam int CNT_W     = LEN_W + 1
) (
  input  logic [LEN_W-1:0] len,
  input  logic             keep_crc,
  output logic [CNT_W-1:0] padded,
  output logic [CNT_W-1:0] even_len,
  output logic [CNT_W-1:0] count,
  output logic [15:0]      status,
  output logic             odd,
  output logic             oversize
);

  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_FRAME);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W:0]   PAGE_C = (CNT_W+1)'(PAGE_BYTES);

  logic [CNT_W-1:0] len_c;
  logic [CNT_W:0]   count_w;

  always_comb begin
    len_c    = CNT_W'(len);
    padded   = (len_c < MIN_C) ? MIN_C : len_c;
    even_len = {padded[CNT_W-1:1], 1'b0};
    odd      = padded[0];
    count_w  = {1'b0, even_len} + (CNT_W+1)'(6) + (keep_crc ? (CNT_W+1)'(4) : '0);
    count    = count_w[CNT_W-1:0];
    oversize = count_w > PAGE_C;
    status   = (odd ? STAT_ODD : 16'h0) | ((padded > MAX_C) ? STAT_LONG : 16'h0);
  end

endmodule

// File: rtl/rxfw_crc32.sv
module rxfw_crc32
  import rxfw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q <= '1;
    end else if (en) begin
      crc_q <= crc_step(crc_q, din);
    end
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/rxfw_ctrl.sv
module rxfw_ctrl
  import rxfw_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  localparam int CNT_W     = LEN_W + 1,
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              keep_crc,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic [CNT_W-1:0]  plan_padded,
  input  logic [CNT_W-1:0]  plan_even,
  input  logic [CNT_W-1:0]  plan_count,
  input  logic [15:0]       plan_status,
  input  logic              plan_odd,
  input  logic              plan_oversize,
  output logic              alloc_req,
  input  logic [7:0]        alloc_page,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [7:0]        byte_data,
  output logic              crc_clear,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  input  logic [31:0]       fcs,
  output logic              mem_we,
  output logic [7:0]        mem_page,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rxq_push,
  output logic [7:0]        rxq_page,
  output logic              rx_done
);

  rx_phase_e        phase_q;
  logic [CNT_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] padded_q, even_q, count_q;
  logic [15:0]      status_q;
  logic             odd_q, keep_q;
  logic [7:0]       page_q;
  logic [7:0]       odd_byte_q;

  logic             reject, need_byte, body_step, body_last;
  logic [7:0]       body_byte;
  logic [CNT_W-1:0] len_c;

  always_comb begin
    len_c     = CNT_W'(len_q);
    reject    = !rx_en || soft_rst || plan_oversize;
    hdr_ready = (phase_q == RX_IDLE);
    need_byte = (phase_q == RX_BODY) && (idx_q < len_c);
    byte_ready = need_byte || (phase_q == RX_DRAIN);
    body_step = (phase_q == RX_BODY) && (!need_byte || byte_valid);
    body_byte = need_byte ? byte_data : 8'h00;
    body_last = (idx_q == padded_q - 1'b1);
    alloc_req = hdr_ready && hdr_valid && !reject;
    crc_clear = hdr_ready;
    crc_en    = body_step;
    crc_din   = body_byte;
    rx_done   = (phase_q == RX_DONE);
    rxq_push  = rx_done;
    rxq_page  = page_q;
    mem_page  = page_q;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    unique case (phase_q)
      RX_HEAD: begin
        mem_we   = 1'b1;
        mem_addr = ADDR_W'(idx_q);
        case (idx_q[1:0])
          2'd0:    mem_wdata = status_q[7:0];
          2'd1:    mem_wdata = status_q[15:8];
          2'd2:    mem_wdata = count_q[7:0];
          default: mem_wdata = 8'(count_q >> 8);
        endcase
      end
      RX_BODY: begin
        mem_we    = body_step && (idx_q < even_q);
        mem_addr  = ADDR_W'(idx_q + CNT_W'(4));
        mem_wdata = body_byte;
      end
      RX_FCS: begin
        mem_we   = 1'b1;
        mem_addr = ADDR_W'(even_q + CNT_W'(4) + idx_q);
        case (idx_q[1:0])
          2'd0:    mem_wdata = fcs[7:0];
          2'd1:    mem_wdata = fcs[15:8];
          2'd2:    mem_wdata = fcs[23:16];
          default: mem_wdata = fcs[31:24];
        endcase
      end
      RX_TAIL: begin
        mem_we   = 1'b1;
        mem_addr = ADDR_W'(count_q - CNT_W'(2) + idx_q);
        if (idx_q[0]) mem_wdata = odd_q ? CTRL_ODD : 8'h00;
        else          mem_wdata = odd_q ? odd_byte_q : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= RX_IDLE;
      idx_q      <= '0;
      len_q      <= '0;
      padded_q   <= '0;
      even_q     <= '0;
      count_q    <= '0;
      status_q   <= '0;
      odd_q      <= 1'b0;
      keep_q     <= 1'b0;
      page_q     <= '0;
      odd_byte_q <= '0;
    end else begin
      unique case (phase_q)
        RX_IDLE: begin
          if (hdr_valid) begin
            idx_q    <= '0;
            len_q    <= hdr_len;
            padded_q <= plan_padded;
            even_q   <= plan_even;
            count_q  <= plan_count;
            status_q <= plan_status;
            odd_q    <= plan_odd;
            keep_q   <= keep_crc;
            page_q   <= alloc_page;
            if (reject || alloc_page == PAGE_NONE) begin
              phase_q <= (hdr_len == '0) ? RX_IDLE : RX_DRAIN;
            end else begin
              phase_q <= RX_HEAD;
            end
          end
        end
        RX_HEAD: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[1:0] == 2'd3) begin
            idx_q   <= '0;
            phase_q <= RX_BODY;
          end
        end
        RX_BODY: begin
          if (body_step) begin
            idx_q <= idx_q + 1'b1;
            if (odd_q && idx_q == even_q) odd_byte_q <= body_byte;
            if (body_last) begin
              idx_q   <= '0;
              phase_q <= keep_q ? RX_FCS : RX_TAIL;
            end
          end
        end
        RX_FCS: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[1:0] == 2'd3) begin
            idx_q   <= '0;
            phase_q <= RX_TAIL;
          end
        end
        RX_TAIL: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q[0]) phase_q <= RX_DONE;
        end
        RX_DONE: phase_q <= RX_IDLE;
        RX_DRAIN: begin
          if (byte_valid) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == len_c - 1'b1) phase_q <= RX_IDLE;
          end
        end
        default: phase_q <= RX_IDLE;
      endcase
    end
  end

  // a dropped frame never touches packet memory
  AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == RX_DRAIN) |-> (!mem_we && !rxq_push)); // R2

  // the padding phase never pulls bytes from the stream
  AST_PAD_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == RX_BODY && idx_q >= len_c) |-> !byte_ready); // R6

endmodule

// File: rtl/rxfw_writer.sv
module rxfw_writer
  import rxfw_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int PAGE_BYTES = 2048,
  localparam int CNT_W     = LEN_W + 1,
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [7:0]        byte_data,
  output logic              alloc_req,
  input  logic [7:0]        alloc_page,
  output logic              mem_we,
  output logic [7:0]        mem_page,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rxq_push,
  output logic [7:0]        rxq_page,
  output logic              rx_done
);

  logic             keep_crc;
  logic [CNT_W-1:0] plan_padded, plan_even, plan_count;
  logic [15:0]      plan_status;
  logic             plan_odd, plan_oversize;
  logic             crc_clear, crc_en;
  logic [7:0]       crc_din;
  logic [31:0]      fcs;

  assign keep_crc = !strip_crc;

  rxfw_plan #(
    .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME), .PAGE_BYTES(PAGE_BYTES)
  ) plan_i (
    .len(hdr_len), .keep_crc(keep_crc),
    .padded(plan_padded), .even_len(plan_even), .count(plan_count),
    .status(plan_status), .odd(plan_odd), .oversize(plan_oversize)
  );

  rxfw_crc32 crc_i (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(crc_en), .din(crc_din), .fcs(fcs)
  );

  rxfw_ctrl #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst), .keep_crc(keep_crc),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len),
    .plan_padded(plan_padded), .plan_even(plan_even), .plan_count(plan_count),
    .plan_status(plan_status), .plan_odd(plan_odd), .plan_oversize(plan_oversize),
    .alloc_req(alloc_req), .alloc_page(alloc_page),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .crc_clear(crc_clear), .crc_en(crc_en), .crc_din(crc_din), .fcs(fcs),
    .mem_we(mem_we), .mem_page(mem_page), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rxq_push(rxq_push), .rxq_page(rxq_page), .rx_done(rx_done)
  );

  AST_READY_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ready && byte_ready)); // R11

  AST_ALLOC_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> (hdr_valid && hdr_ready && rx_en && !soft_rst)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R10

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_we)); // R10

  AST_WRITE_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R5

  AST_PUSH_REAL_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> (rxq_page != PAGE_NONE)); // R4

endmodule

// File: tb/rxfw_writer_tb_top.sv
module rxfw_writer_tb_top;

  localparam int LEN_W  = 10;
  localparam int MINF   = 64;
  localparam int MAXF   = 120;
  localparam int PAGE_B = 256;
  localparam int ADDR_W = $clog2(PAGE_B);
  localparam int NVEC   = 15;

  // {len[11:0], page[7:0], seed[7:0], strip, en, srst, gap}
  localparam logic [31:0] VEC [NVEC] = '{
    {12'd10,  8'd3,   8'h11, 4'b0100},
    {12'd64,  8'd1,   8'h22, 4'b1101},
    {12'd65,  8'd2,   8'h33, 4'b0100},
    {12'd63,  8'd0,   8'h44, 4'b0100},
    {12'd121, 8'd5,   8'h55, 4'b1100},
    {12'd120, 8'd6,   8'h66, 4'b0100},
    {12'd247, 8'd7,   8'h77, 4'b0100},
    {12'd248, 8'd1,   8'h88, 4'b0100},
    {12'd251, 8'd2,   8'h99, 4'b1100},
    {12'd252, 8'd3,   8'hAA, 4'b1100},
    {12'd80,  8'd4,   8'hBB, 4'b0000},
    {12'd80,  8'd4,   8'hCC, 4'b0110},
    {12'd90,  8'h80,  8'hDD, 4'b0100},
    {12'd0,   8'd5,   8'hEE, 4'b0100},
    {12'd101, 8'd0,   8'h0F, 4'b1101}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, soft_rst = 1'b0, strip_crc = 1'b0;
  logic hdr_valid = 1'b0;
  logic hdr_ready;
  logic [LEN_W-1:0] hdr_len = '0;
  logic byte_valid = 1'b0;
  logic byte_ready;
  logic [7:0] byte_data = '0;
  logic alloc_req;
  logic [7:0] alloc_page = '0;
  logic mem_we;
  logic [7:0] mem_page;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic rxq_push;
  logic [7:0] rxq_page;
  logic rx_done;

  always #2 clk = ~clk;

  rxfw_writer #(.LEN_W(LEN_W), .MIN_FRAME(MINF), .MAX_FRAME(MAXF), .PAGE_BYTES(PAGE_B)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_len(hdr_len),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .alloc_req(alloc_req), .alloc_page(alloc_page),
    .mem_we(mem_we), .mem_page(mem_page), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rxq_push(rxq_push), .rxq_page(rxq_page), .rx_done(rx_done)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  int wr_cnt, done_cnt, alloc_cnt, last_wr, done_cyc, page_err, overlap;
  logic [7:0] push_page, cur_page;
  logic [7:0] mem_model [PAGE_B];
  logic [7:0] exp_b [PAGE_B];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (mem_we) begin
      wr_cnt++;
      last_wr = cyc;
      mem_model[mem_addr] = mem_wdata;
      if (mem_page != cur_page) page_err++;
    end
    if (rx_done) begin
      done_cnt++;
      done_cyc = cyc;
      push_page = rxq_push ? rxq_page : 8'hFF;
    end
    if (alloc_req) alloc_cnt++;
    if (hdr_ready && byte_ready) overlap++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return 8'(seed + 8'(k * 7));
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic clear_mon();
    wr_cnt = 0; done_cnt = 0; alloc_cnt = 0; last_wr = -10; done_cyc = -1;
    page_err = 0; push_page = 8'hFF;
    for (int a = 0; a < PAGE_B; a++) mem_model[a] = 8'hEE;
  endtask

  task automatic send_hdr(input int len);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_len = LEN_W'(len);
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  // called at a negedge; returns at a negedge with valid low
  task automatic send_bytes(input int n, input logic [7:0] seed, input bit gap);
    int k = 0;
    int g = 0;
    while (k < n) begin
      byte_valid = !(gap && (g % 3 == 0));
      byte_data = pat(seed, k);
      g++;
      #1;
      if (byte_valid && byte_ready) k++;
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic wait_idle();
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [31:0] v);
    int len, padded, even, cnt, bad_pay, bad_pad, bad_crc;
    bit strip, en, srst, gap, odd, drop, no_alloc;
    logic [7:0] page, seed;
    logic [15:0] status;
    logic [31:0] crc;
    string rtag;
    len = int'(v[31:20]); page = v[19:12]; seed = v[11:4];
    strip = v[3]; en = v[2]; srst = v[1]; gap = v[0];
    padded = (len < MINF) ? MINF : len;
    even = padded & ~1;
    odd = padded[0];
    cnt = even + 6 + (strip ? 0 : 4);
    status = (odd ? 16'h1000 : 16'h0) | ((padded > MAXF) ? 16'h0800 : 16'h0);
    crc = 32'hFFFFFFFF;
    for (int k = 0; k < padded; k++) crc = ref_crc(crc, (k < len) ? pat(seed, k) : 8'h00);
    crc = ~crc;
    exp_b[0] = status[7:0]; exp_b[1] = status[15:8];
    exp_b[2] = 8'(cnt); exp_b[3] = 8'(cnt >> 8);
    for (int k = 0; k < even; k++) exp_b[4 + k] = (k < len) ? pat(seed, k) : 8'h00;
    if (!strip) for (int j = 0; j < 4; j++) exp_b[4 + even + j] = 8'(crc >> (8 * j));
    exp_b[cnt - 2] = odd ? pat(seed, padded - 1) : 8'h00;
    exp_b[cnt - 1] = odd ? 8'h20 : 8'h00;

    if (!en || srst)          begin drop = 1; no_alloc = 1; rtag = "R2"; end
    else if (cnt > PAGE_B)    begin drop = 1; no_alloc = 1; rtag = "R3"; end
    else if (page == 8'h80)   begin drop = 1; no_alloc = 0; rtag = "R4"; end
    else                      begin drop = 0; no_alloc = 0; rtag = "R10"; end

    clear_mon();
    cur_page = page;
    rx_en = en; soft_rst = srst; strip_crc = strip; alloc_page = page;
    send_hdr(len);
    send_bytes(len, seed, gap);
    wait_idle();

    if (drop) begin
      chk(wr_cnt == 0, rtag, $sformatf("len %0d dropped, writes", len), wr_cnt, 0);
      chk(done_cnt == 0, rtag, "dropped, done pulses", done_cnt, 0);
      chk(alloc_cnt == (no_alloc ? 0 : 1), rtag, "dropped, alloc requests", alloc_cnt, no_alloc ? 0 : 1);
    end else begin
      chk(wr_cnt == cnt, "R10", $sformatf("len %0d write count", len), wr_cnt, cnt);
      chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
      chk(done_cyc == last_wr + 1, "R10", "done cycle after last write", done_cyc, last_wr + 1);
      chk(push_page == page, "R10", "pushed page", push_page, page);
      chk(page_err == 0, "R10", "writes to wrong page", page_err, 0);
      chk(alloc_cnt == 1, "R10", "alloc requests", alloc_cnt, 1);
      chk({mem_model[1], mem_model[0]} == status, "R7", "status word",
          {mem_model[1], mem_model[0]}, status);
      chk({mem_model[3], mem_model[2]} == 16'(cnt), "R5", "stored count",
          {mem_model[3], mem_model[2]}, cnt);
      bad_pay = 0; bad_pad = 0; bad_crc = 0;
      for (int k = 0; k < even; k++) begin
        if (mem_model[4 + k] !== exp_b[4 + k]) begin
          if (k < len) bad_pay++; else bad_pad++;
        end
      end
      chk(bad_pay == 0, gap ? "R11" : "R5", "payload byte mismatches", bad_pay, 0);
      if (len < MINF) chk(bad_pad == 0, "R6", "padding byte mismatches", bad_pad, 0);
      if (!strip) begin
        for (int j = 0; j < 4; j++) if (mem_model[4 + even + j] !== exp_b[4 + even + j]) bad_crc++;
        chk(bad_crc == 0, "R8", $sformatf("crc bytes, first %0h", mem_model[4 + even]),
            bad_crc, 0);
      end else begin
        chk(mem_model[4 + even] === exp_b[4 + even], "R8", "stripped: no crc before trailer",
            mem_model[4 + even], exp_b[4 + even]);
      end
      chk(mem_model[cnt - 2] === exp_b[cnt - 2], "R9", "trailer data byte", mem_model[cnt - 2], exp_b[cnt - 2]);
      chk(mem_model[cnt - 1] === exp_b[cnt - 1], "R9", "trailer control byte", mem_model[cnt - 1], exp_b[cnt - 1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    overlap = 0;
    clear_mon();
    cur_page = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(hdr_ready == 1'b1, "R1", "hdr_ready after reset", hdr_ready, 1);
    chk(byte_ready == 1'b0, "R1", "byte_ready after reset", byte_ready, 0);
    chk(!mem_we && !rxq_push && !rx_done, "R1", "no activity after reset",
        mem_we | rxq_push | rx_done, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // reset in the middle of a frame
    rx_en = 1'b1; soft_rst = 1'b0; strip_crc = 1'b0; alloc_page = 8'd2; cur_page = 8'd2;
    send_hdr(100);
    send_bytes(30, 8'h5A, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
    @(negedge clk); #1;
    chk(hdr_ready == 1'b1 && byte_ready == 1'b0, "R1", "ready state after mid-frame reset",
        {hdr_ready, byte_ready}, 2);
    repeat (4) @(negedge clk);
    chk(wr_cnt == 0 && done_cnt == 0, "R1", "no writes after mid-frame reset", wr_cnt + done_cnt, 0);
    run_vec({12'd70, 8'd1, 8'h3C, 4'b0101});

    chk(overlap == 0, "R11", "cycles with both readies high", overlap, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule